// File: doc/BRIEF.md
# Cascadable Synchronous Counter Stage

This block is a binary up-counter slice, four bits wide by default, with a parallel preset and a terminal-count flag. It is meant for chaining. All state bits update together on the rising clock edge. An active-low load input copies the data word into the counter, and it does so whatever the enables are. The counter advances by one only when both of its count enables are high. One enable (`cnt_en_p`) acts on this stage alone. The other (`cnt_en_t`) also gates the terminal-count output, so a wider counter is built by connecting each stage's `term_cnt` to the next stage's `cnt_en_t`, with the load and parallel enable shared by all stages.

A build-time parameter selects how the active-low clear behaves:
- **Synchronous clear:** the clear acts at the next rising edge and overrides load and count. Feeding a decode of a chosen final state back to the clear input shortens the counting modulus.
- **Asynchronous clear:** the clear forces the state to zero at once, with no clock edge needed.

Top module: `casc_count_stage`

## Requirements
- R1: With the synchronous clear selected, `rst_n` low at a rising edge makes `count_q` zero after that edge, whatever `load_n`, `cnt_en_p` and `cnt_en_t` are.
- R2: With the asynchronous clear selected, `rst_n` low forces `count_q` to zero and `term_cnt` low without waiting for a clock edge.
- R3: With the clear inactive, `load_n` low at a rising edge loads `data_in` into `count_q`, whatever the levels of both count enables.
- R4: With the clear inactive and `load_n` high, `count_q` increases by one at a rising edge when `cnt_en_p` and `cnt_en_t` are both high.
- R5: With the clear inactive and `load_n` high, `count_q` keeps its value at a rising edge when either count enable is low.
- R6: Counting runs through every value from 0 to 2^WIDTH-1, and the all-ones value steps to 0.
- R7: `term_cnt` is high exactly when `cnt_en_t` is high and `count_q` is all ones. It follows `cnt_en_t` with no clock delay and does not depend on `load_n` or `cnt_en_p`.
- R8: Stages chained through `term_cnt` into `cnt_en_t`, with `load_n` and `cnt_en_p` shared, count as one wider binary counter, including the wrap from all ones to zero. They hold when `cnt_en_p` is low.
- R9: With the synchronous clear driven low by a decode of `count_q` equal to 6, a counting stage repeats the sequence 0, 1, 2, 3, 4, 5, 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, synchronous or asynchronous according to `CLR_STYLE` |
| load_n | input | 1 | Active-low parallel load |
| data_in | input | WIDTH | Preset value |
| cnt_en_p | input | 1 | Count enable that acts on this stage only |
| cnt_en_t | input | 1 | Count enable that also gates `term_cnt` |
| count_q | output | WIDTH | Counter state |
| term_cnt | output | 1 | High when `cnt_en_t` is high and the state is all ones |

## Verification
The assertions assume that `load_n`, `data_in` and both enables are stable around each rising edge. They also assume that any clear activity switches the checks off through their reset qualifier.

The stimulus keeps to these assumptions. It changes every input just after a clock edge. It also holds the clear low across a whole edge whenever it asserts it, which leaves a full cycle before the next sampling edge.

Each sweep starts from a freshly loaded value. It then applies one combination of clear, load and enables, so every start value meets every operation in both clear styles.

// File: rtl/cnt_pkg.sv
// Shared types for the cascadable counter stage.
package cnt_pkg;

    // Build-time choice of how the active-low clear acts.
    typedef enum logic {
        CLR_SYNC  = 1'b0,
        CLR_ASYNC = 1'b1
    } clr_style_e;

    // Operation applied at the next rising edge, highest priority first.
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/cnt_op_select.sv
// Chooses the operation for the coming edge.
// Priority: synchronous clear, then load, then count, then hold.
// Assumes sync_clr is already qualified by the clear style (it is 0 in
// asynchronous mode).
module cnt_op_select
    import cnt_pkg::*;
(
    input  logic    sync_clr,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);

    // Fixed-priority decode of the control inputs.
    always_comb begin
        if (sync_clr)          op = OP_CLEAR;
        else if (!load_n)      op = OP_LOAD;
        else if (en_p && en_t) op = OP_COUNT;
        else                   op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_next_state.sv
// Forms the next counter value from the chosen operation.
// The increment uses a look-ahead carry: each bit toggles when all lower
// bits are one. Assumes op comes from cnt_op_select.
module cnt_next_state
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] incr;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_inc
        // Toggle bit i when every lower bit is one.
        assign incr[i]      = cur[i] ^ carry[i];
        assign carry[i + 1] = carry[i] & cur[i];
    end

    // Select the next value for the operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_COUNT: nxt = incr;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_state_reg.sv
// One flop per state bit, all clocked by the same rising edge.
// An active-low asynchronous clear is always present. The top ties it high
// when the synchronous style is chosen.
module cnt_state_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Capture bit i on the rising edge, or clear it at once.
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) q[i] <= 1'b0;
            else         q[i] <= d[i];
        end
    end

endmodule

// File: rtl/cnt_tc_decode.sv
// Terminal-count decode: high when the state is all ones and the trickle
// enable is high. Purely combinational, so an enable change passes with no
// clock delay.
module cnt_tc_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_t,
    output logic             tc
);

    // All-ones detect gated by the trickle enable.
    always_comb tc = en_t & (&cur);

endmodule

// File: rtl/casc_count_stage.sv
// Cascadable up-counter stage with parallel preset, two count enables and a
// terminal-count output.
// CLR_STYLE picks either a synchronous or an asynchronous active-low clear.
// Assumes the control inputs meet setup and hold at the rising edge.
module casc_count_stage
    import cnt_pkg::*;
#(
    parameter int         WIDTH     = 4,
    parameter clr_style_e CLR_STYLE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic             cnt_en_p,
    input  logic             cnt_en_t,
    output logic [WIDTH-1:0] count_q,
    output logic             term_cnt
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic             sync_clr;
    logic             arst_n;
    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;

    // Route the clear to the edge path or the flop clear by style.
    if (CLR_STYLE == CLR_ASYNC) begin : g_async_clr
        assign sync_clr = 1'b0;
        assign arst_n   = rst_n;
    end else begin : g_sync_clr
        assign sync_clr = ~rst_n;
        assign arst_n   = 1'b1;
    end

    cnt_op_select u_sel (
        .sync_clr (sync_clr),
        .load_n   (load_n),
        .en_p     (cnt_en_p),
        .en_t     (cnt_en_t),
        .op       (op)
    );

    cnt_next_state #(.WIDTH(WIDTH)) u_next (
        .op     (op),
        .cur    (count_q),
        .preset (data_in),
        .nxt    (nxt)
    );

    cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (nxt),
        .q      (count_q)
    );

    cnt_tc_decode #(.WIDTH(WIDTH)) u_tc (
        .cur  (count_q),
        .en_t (cnt_en_t),
        .tc   (term_cnt)
    );

    // Load takes the preset whatever the enables are.
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count_q == $past(data_in));

    // Both enables high with no load advances the state by one.
    p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_n && cnt_en_p && cnt_en_t |=> count_q == WIDTH'($past(count_q) + 1'b1));

    // Either enable low with no load leaves the state unchanged.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_n && !(cnt_en_p && cnt_en_t) |=> $stable(count_q));

    // The all-ones state steps to zero when counting.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_n && cnt_en_p && cnt_en_t && count_q == ALL_ONES |=> count_q == '0);

    // Terminal count implies the trickle enable, and with counting it
    // forecasts a wrap to zero.
    p_tc_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |-> cnt_en_t);
    p_tc_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt && load_n && cnt_en_p |=> count_q == '0);

endmodule

// File: tb/casc_count_stage_tb.sv
// Self-checking bench.
// - Near-exhaustive operation sweep on a synchronous-clear and an
//   asynchronous-clear stage.
// - A full count run through the wrap.
// - A three-stage cascade.
// - A modulus-7 counter built on the synchronous clear.
module casc_count_stage_tb;
    import cnt_pkg::*;

    localparam int W      = 4;
    localparam int NSTAGE = 3;
    localparam int CW     = W * NSTAGE;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    // Shared stimulus for the two single stages.
    logic         rst_n  = 1'b0;
    logic         load_n = 1'b1;
    logic         en_p   = 1'b0;
    logic         en_t   = 1'b0;
    logic [W-1:0] din    = '0;
    logic [W-1:0] q_s, q_a;
    logic         tc_s, tc_a;

    casc_count_stage #(.WIDTH(W), .CLR_STYLE(CLR_SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .data_in(din),
        .cnt_en_p(en_p), .cnt_en_t(en_t), .count_q(q_s), .term_cnt(tc_s));

    casc_count_stage #(.WIDTH(W), .CLR_STYLE(CLR_ASYNC)) u_dut_async (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .data_in(din),
        .cnt_en_p(en_p), .cnt_en_t(en_t), .count_q(q_a), .term_cnt(tc_a));

    // Cascade of stages: each term_cnt feeds the next trickle enable.
    logic              c_rst_n  = 1'b0;
    logic              c_load_n = 1'b1;
    logic              c_en_p   = 1'b0;
    logic [CW-1:0]     c_din    = '0;
    logic [CW-1:0]     c_q;
    logic [NSTAGE:0]   c_chain;
    assign c_chain[0] = 1'b1;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        casc_count_stage #(.WIDTH(W), .CLR_STYLE(CLR_SYNC)) u_st (
            .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n),
            .data_in(c_din[s*W +: W]), .cnt_en_p(c_en_p),
            .cnt_en_t(c_chain[s]), .count_q(c_q[s*W +: W]),
            .term_cnt(c_chain[s+1]));
    end

    // Modulus-7 counter: a decode of state 6 drives the synchronous clear.
    logic         m_boot_n = 1'b0;
    logic [W-1:0] m_q;
    logic         m_tc;
    logic         m_clr_n;
    assign m_clr_n = m_boot_n & (m_q != W'(6));

    casc_count_stage #(.WIDTH(W), .CLR_STYLE(CLR_SYNC)) u_mod (
        .clk(clk), .rst_n(m_clr_n), .load_n(1'b1), .data_in('0),
        .cnt_en_p(1'b1), .cnt_en_t(1'b1), .count_q(m_q), .term_cnt(m_tc));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset state (R1 sync, R2 async).
        tick(); tick();
        chk("R1 reset q", int'(q_s), 0);
        chk("R2 reset q", int'(q_a), 0);
        chk("R7 reset tc", int'(tc_s), 0);
        chk("R2 reset tc", int'(tc_a), 0);

        // Sweep: every start value against every control combination.
        for (int start = 0; start < 16; start++) begin
            for (int combo = 0; combo < 16; combo++) begin
                int r, l, p, t, expq, exptc;
                rst_n = 1'b1; load_n = 1'b0; en_p = 1'b0; en_t = 1'b0;
                din = W'(start);
                tick();
                chk("R3 preload sync", int'(q_s), start);
                chk("R3 preload async", int'(q_a), start);

                r = (combo >> 3) & 1; l = (combo >> 2) & 1;
                p = (combo >> 1) & 1; t = combo & 1;
                rst_n = r[0]; load_n = l[0]; en_p = p[0]; en_t = t[0];
                din = W'(~start);
                #1;
                // R7: decode follows en_t at once; load/en_p play no part.
                exptc = (t == 1 && start == 15) ? 1 : 0;
                chk("R7 tc sync", int'(tc_s), exptc);
                chk("R2 async q immediate", int'(q_a), (r == 1) ? start : 0);
                chk("R2 async tc", int'(tc_a), (r == 1) ? exptc : 0);

                if (r == 0)           expq = 0;                     // R1
                else if (l == 0)      expq = (~start) & 15;         // R3
                else if (p && t)      expq = (start + 1) % 16;      // R4 R6
                else                  expq = start;                 // R5
                tick();
                chk((r == 0) ? "R1 clear" : (l == 0) ? "R3 load" :
                    (p && t) ? "R4 count" : "R5 hold", int'(q_s), expq);
                chk("R2 async edge", int'(q_a), expq);
            end
        end

        // Full run through the wrap (R6).
        rst_n = 1'b1; load_n = 1'b0; din = '0; en_p = 1'b0; en_t = 1'b0;
        tick();
        load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            tick();
            chk("R6 run", int'(q_s), k % 16);
        end

        // Cascade (R8).
        c_rst_n = 1'b1; c_load_n = 1'b0; c_din = '0;
        tick();
        c_load_n = 1'b1; c_en_p = 1'b1;
        for (int k = 1; k <= 300; k++) begin
            tick();
            chk("R8 cascade count", int'(c_q), k);
        end
        c_en_p = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R8 cascade hold", int'(c_q), 300);
        end
        c_load_n = 1'b0; c_din = CW'(4090);
        tick();
        chk("R8 cascade load", int'(c_q), 4090);
        c_load_n = 1'b1; c_en_p = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            tick();
            chk("R8 cascade wrap", int'(c_q), (4090 + k) % 4096);
        end
        c_en_p = 1'b0;

        // Modulus 7 via decoded synchronous clear (R9).
        tick();
        chk("R9 mod boot", int'(m_q), 0);
        m_boot_n = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            tick();
            chk("R9 mod sequence", int'(m_q), k % 7);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule